// File: doc/BRIEF.md
# Bus Transmitter Fault Diagnostic Logic

This block is the digital fault monitor for a differential two-wire bus driver. It watches the transmit controls, the data echoed back by the receiver and a set of analog comparator outputs. From these it keeps a registered flag for each fault it can observe: transmit and receive edges that do not pair up, low or high current in each of the four output drivers, a short between the two lines, excess die temperature, and a transmitter that has been left on for too long. It also forms per-line open, short-to-supply and short-to-ground indications, an aggregate error output, and the gated enable that switches the output stage on.

Current and line-short comparators give meaningful answers only once the driven level has settled. The block therefore times each stable transmit level with one counter, and samples these comparators only after a configurable settling window. All windows are counted in clock cycles. Flags keep their value whenever their update condition is false, and the power-off mode clears all of them.

Top module: `bus_diag_top`

## Requirements
- R1: `txDrive` is high exactly when `mode` is 2'b10 (normal; 2'b00 is power-off, 2'b01 standby, 2'b11 treated like standby), `txEnN` is low, `guardEn` is high, and neither `txTimeout` nor `overTemp` is set.
- R2: While `txDrive` is high, a rising edge on `txData` that follows an earlier rising edge with no `rxData` rising edge between them sets `busErr`. The flag is set on the clock edge that samples the second rise.
- R3: The same pairing rule applies to falling edges: a second `txData` fall with no `rxData` fall after the first one sets `busErr`.
- R4: While `txDrive` is high, an `rxData` rise after an unanswered `txData` rise (or an `rxData` fall after an unanswered `txData` fall) clears `busErr`, unless a set condition occurs on the same edge, in which case set wins.
- R5: `busErr` holds its value while `txDrive` is low. Edge pairing restarts when the transmitter is enabled again.
- R6: `lowFlags` and `highFlags` index the drivers as bit 0 plus-line high-side, bit 1 plus-line low-side, bit 2 minus-line high-side, bit 3 minus-line low-side. Once `txData` has been unchanged with `txDrive` high for ERR_CYC+1 consecutive clock edges, each later such edge copies `curLow`/`curHigh` into bits 0 and 3 when `txData` is 1, and into bits 1 and 2 when `txData` is 0. At all other times these bits hold.
- R7: For each line (bit 0 plus, bit 1 minus), `openLine` is the AND of both drivers' low-current flags. `shortSup` is high-side low-current AND low-side high-current. `shortGnd` is high-side high-current AND low-side low-current.
- R8: `lineShort` takes `shortCmp` once per stable level, on the ERR_CYC+1-th steady transmitting edge after a `txData` change, and holds otherwise.
- R9: `txTimeout` sets after TO_CYC consecutive clock edges with normal mode, `txEnN` low and `guardEn` high, counted from the edge after the last change of `txEnN` or `guardEn`.
- R10: `txTimeout` and its count clear on any change of `txEnN` or `guardEn`, or whenever mode is not normal.
- R11: `overTemp` follows `overTempCmp` only in normal mode and holds otherwise. When set, it forces `txDrive` low.
- R12: `anyErr` is the OR of `busErr`, every bit of `lowFlags` and `highFlags`, `lineShort`, `overTemp`, `txTimeout` and `ioUnderVolt`.
- R13: After reset, and on every clock edge in power-off mode, all flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 off, 01 standby, 10 normal, 11 standby-like |
| txData | input | 1 | Transmit data (1 = Data1, 0 = Data0) |
| txEnN | input | 1 | Active-low transmit enable |
| guardEn | input | 1 | Guardian enable, active high |
| rxData | input | 1 | Received data from the bus receiver |
| curLow | input | 4 | Low-current comparators, one per driver |
| curHigh | input | 4 | High-current comparators, one per driver |
| shortCmp | input | 1 | Line-to-line short comparator |
| overTempCmp | input | 1 | Over-temperature comparator (hysteresis outside) |
| ioUnderVolt | input | 1 | I/O supply undervoltage flag |
| txDrive | output | 1 | Gated enable for the output stage |
| busErr | output | 1 | Transmit/receive edge pairing error |
| lowFlags | output | 4 | Per-driver low-current flags |
| highFlags | output | 4 | Per-driver high-current flags |
| openLine | output | 2 | Open line, bit 0 plus, bit 1 minus |
| shortSup | output | 2 | Line short to supply |
| shortGnd | output | 2 | Line short to ground |
| lineShort | output | 1 | Short between the two lines |
| overTemp | output | 1 | Over-temperature flag |
| txTimeout | output | 1 | Transmitter-on timeout flag |
| anyErr | output | 1 | Aggregate error |

## Verification
Every flag is a register, so its new value is visible one clock after the edge that samples the triggering input. `txDrive`, `anyErr` and the derived line flags are combinational on those registers and the inputs. Current and line-short samples appear ERR_CYC+1 edges after the edge that saw the last `txData` change, and the timeout appears TO_CYC edges after the last control change. The bench drives inputs just after a falling clock edge, steps a behavioural model at each rising edge from the same inputs, and compares every output at the next falling edge, so each result is checked in the exact cycle it falls due.

// File: rtl/bus_diag_pkg.sv
package bus_diag_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_STBY = 2'b01,
    MODE_NORM = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;

  localparam int unsigned NUM_DRV   = 4;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned DRV_P_HI  = 0;
  localparam int unsigned DRV_P_LO  = 1;
  localparam int unsigned DRV_M_HI  = 2;
  localparam int unsigned DRV_M_LO  = 3;

  typedef struct packed {
    logic txActive;
    logic txRise;
    logic txFall;
    logic rxRise;
    logic rxFall;
    logic evalLevel;
    logic shortSample;
    logic powerOff;
    logic updTemp;
  } strobe_t;

endpackage

// File: rtl/bus_diag_ctrl.sv
module bus_diag_ctrl
  import bus_diag_pkg::*;
#(
  parameter int unsigned ERR_CYC = 4000,
  parameter int unsigned TO_CYC  = 128000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       txData,
  input  logic       txEnN,
  input  logic       guardEn,
  input  logic       rxData,
  input  logic       overTemp,
  output strobe_t    strb,
  output logic       txTimeout,
  output logic       txDrive
);

  localparam int unsigned LVL_W = $clog2(ERR_CYC + 2);
  localparam int unsigned TO_W  = $clog2(TO_CYC + 1);
  localparam logic [LVL_W-1:0] ERR_LIM = LVL_W'(ERR_CYC);
  localparam logic [TO_W-1:0]  TO_LIM  = TO_W'(TO_CYC - 1);

  logic txPrev, rxPrev, enPrev, gePrev;
  logic [LVL_W-1:0] levelCnt;
  logic [TO_W-1:0]  toCnt;
  logic toFlag;
  logic isNorm, isOff, drvReq, ctlEdge, steady;

  assign isNorm   = (mode == MODE_NORM);
  assign isOff    = (mode == MODE_OFF);
  assign drvReq   = isNorm && !txEnN && guardEn;
  assign txDrive  = drvReq && !toFlag && !overTemp;
  assign ctlEdge  = (txEnN != enPrev) || (guardEn != gePrev);
  assign steady   = txDrive && (txData == txPrev);
  assign txTimeout = toFlag;

  always_comb begin
    strb.txActive    = txDrive;
    strb.txRise      = txData && !txPrev;
    strb.txFall      = !txData && txPrev;
    strb.rxRise      = rxData && !rxPrev;
    strb.rxFall      = !rxData && rxPrev;
    strb.evalLevel   = steady && (levelCnt >= ERR_LIM);
    strb.shortSample = steady && (levelCnt == ERR_LIM);
    strb.powerOff    = isOff;
    strb.updTemp     = isNorm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPrev <= 1'b0;
      rxPrev <= 1'b0;
      enPrev <= 1'b1;
      gePrev <= 1'b0;
    end else begin
      txPrev <= txData;
      rxPrev <= rxData;
      enPrev <= txEnN;
      gePrev <= guardEn;
    end
  end

  // settle timer for the current transmit level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelCnt <= '0;
    end else if (!steady) begin
      levelCnt <= '0;
    end else if (levelCnt <= ERR_LIM) begin
      levelCnt <= levelCnt + 1'b1;
    end
  end

  // transmitter-on watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt  <= '0;
      toFlag <= 1'b0;
    end else if (ctlEdge || !isNorm) begin
      toCnt  <= '0;
      toFlag <= 1'b0;
    end else if (drvReq && !toFlag) begin
      if (toCnt == TO_LIM) toFlag <= 1'b1;
      else                 toCnt  <= toCnt + 1'b1;
    end
  end

  AST_TO_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txTimeout) |-> $past(drvReq)); // R9
  AST_TO_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEdge || !isNorm) |=> !txTimeout); // R10
  AST_SHORT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.shortSample |=> !strb.shortSample); // R8

endmodule

// File: rtl/bus_diag_datapath.sv
module bus_diag_datapath
  import bus_diag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               txData,
  input  logic [NUM_DRV-1:0] curLow,
  input  logic [NUM_DRV-1:0] curHigh,
  input  logic               shortCmp,
  input  logic               overTempCmp,
  input  logic               ioUnderVolt,
  input  logic               txTimeout,
  output logic               busErr,
  output logic [NUM_DRV-1:0] lowFlags,
  output logic [NUM_DRV-1:0] highFlags,
  output logic [NUM_LINES-1:0] openLine,
  output logic [NUM_LINES-1:0] shortSup,
  output logic [NUM_LINES-1:0] shortGnd,
  output logic               lineShort,
  output logic               overTemp,
  output logic               anyErr
);

  logic pendRise, pendFall, setErr, clrErr;

  assign setErr = (strb.txRise && pendRise && !strb.rxRise) ||
                  (strb.txFall && pendFall && !strb.rxFall);
  assign clrErr = (strb.rxRise && pendRise) || (strb.rxFall && pendFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busErr   <= 1'b0;
      pendRise <= 1'b0;
      pendFall <= 1'b0;
    end else if (strb.powerOff || !strb.txActive) begin
      pendRise <= 1'b0;
      pendFall <= 1'b0;
      if (strb.powerOff) busErr <= 1'b0;
    end else begin
      if (setErr)      busErr <= 1'b1;
      else if (clrErr) busErr <= 1'b0;
      if (strb.txRise)      pendRise <= 1'b1;
      else if (strb.rxRise) pendRise <= 1'b0;
      if (strb.txFall)      pendFall <= 1'b1;
      else if (strb.rxFall) pendFall <= 1'b0;
    end
  end

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    localparam logic ON_DATA1 = (d == DRV_P_HI) || (d == DRV_M_LO);
    logic lowQ, highQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lowQ  <= 1'b0;
        highQ <= 1'b0;
      end else if (strb.powerOff) begin
        lowQ  <= 1'b0;
        highQ <= 1'b0;
      end else if (strb.evalLevel && (txData == ON_DATA1)) begin
        lowQ  <= curLow[d];
        highQ <= curHigh[d];
      end
    end
    assign lowFlags[d]  = lowQ;
    assign highFlags[d] = highQ;
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam int unsigned HI = (l == 0) ? DRV_P_HI : DRV_M_HI;
    localparam int unsigned LO = (l == 0) ? DRV_P_LO : DRV_M_LO;
    assign openLine[l] = lowFlags[HI]  & lowFlags[LO];
    assign shortSup[l] = lowFlags[HI]  & highFlags[LO];
    assign shortGnd[l] = highFlags[HI] & lowFlags[LO];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineShort <= 1'b0;
      overTemp  <= 1'b0;
    end else if (strb.powerOff) begin
      lineShort <= 1'b0;
      overTemp  <= 1'b0;
    end else begin
      if (strb.shortSample) lineShort <= shortCmp;
      if (strb.updTemp)     overTemp  <= overTempCmp;
    end
  end

  assign anyErr = busErr | (|lowFlags) | (|highFlags) | lineShort |
                  overTemp | txTimeout | ioUnderVolt;

  AST_BUSERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.txActive && !strb.powerOff) |=> $stable(busErr)); // R5
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.powerOff |=> (!busErr && lowFlags == '0 && highFlags == '0 &&
                       !lineShort && !overTemp)); // R13
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.evalLevel && !strb.powerOff) |=> ($stable(lowFlags) && $stable(highFlags))); // R6
  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.updTemp && !strb.powerOff) |=> $stable(overTemp)); // R11

endmodule

// File: rtl/bus_diag_top.sv
module bus_diag_top
  import bus_diag_pkg::*;
#(
  parameter int unsigned ERR_CYC = 4000,
  parameter int unsigned TO_CYC  = 128000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       txData,
  input  logic       txEnN,
  input  logic       guardEn,
  input  logic       rxData,
  input  logic [3:0] curLow,
  input  logic [3:0] curHigh,
  input  logic       shortCmp,
  input  logic       overTempCmp,
  input  logic       ioUnderVolt,
  output logic       txDrive,
  output logic       busErr,
  output logic [3:0] lowFlags,
  output logic [3:0] highFlags,
  output logic [1:0] openLine,
  output logic [1:0] shortSup,
  output logic [1:0] shortGnd,
  output logic       lineShort,
  output logic       overTemp,
  output logic       txTimeout,
  output logic       anyErr
);

  strobe_t strb;

  bus_diag_ctrl #(.ERR_CYC(ERR_CYC), .TO_CYC(TO_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .txData(txData), .txEnN(txEnN),
    .guardEn(guardEn), .rxData(rxData), .overTemp(overTemp),
    .strb(strb), .txTimeout(txTimeout), .txDrive(txDrive)
  );

  bus_diag_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData),
    .curLow(curLow), .curHigh(curHigh), .shortCmp(shortCmp),
    .overTempCmp(overTempCmp), .ioUnderVolt(ioUnderVolt),
    .txTimeout(txTimeout), .busErr(busErr), .lowFlags(lowFlags),
    .highFlags(highFlags), .openLine(openLine), .shortSup(shortSup),
    .shortGnd(shortGnd), .lineShort(lineShort), .overTemp(overTemp),
    .anyErr(anyErr)
  );

  AST_TEMP_GATES_TX: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |-> !txDrive); // R11

endmodule

// File: tb/bus_diag_top_tb.sv
module bus_diag_top_tb;

  localparam int ERR = 6;
  localparam int TO  = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'b00;
  logic txData = 1'b0, txEnN = 1'b1, ge = 1'b0, rxData = 1'b0;
  logic [3:0] curLow = '0, curHigh = '0;
  logic shortCmp = 1'b0, otc = 1'b0, iouv = 1'b0;
  logic txDrive, busErr, lineShort, overTemp, txTimeout, anyErr;
  logic [3:0] lowFlags, highFlags;
  logic [1:0] openLine, shortSup, shortGnd;

  always #2.5 clk = ~clk;

  bus_diag_top #(.ERR_CYC(ERR), .TO_CYC(TO)) u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .txData(txData), .txEnN(txEnN),
    .guardEn(ge), .rxData(rxData), .curLow(curLow), .curHigh(curHigh),
    .shortCmp(shortCmp), .overTempCmp(otc), .ioUnderVolt(iouv),
    .txDrive(txDrive), .busErr(busErr), .lowFlags(lowFlags),
    .highFlags(highFlags), .openLine(openLine), .shortSup(shortSup),
    .shortGnd(shortGnd), .lineShort(lineShort), .overTemp(overTemp),
    .txTimeout(txTimeout), .anyErr(anyErr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic mTxPrev = 0, mRxPrev = 0, mEnPrev = 1, mGePrev = 0;
  logic mPendR = 0, mPendF = 0, mBusErr = 0, mShort = 0, mOt = 0, mTo = 0;
  logic [3:0] mLow = '0, mHigh = '0;
  int lvl = 0, toCnt = 0;
  logic nrm, drvReq, act, tR, tF, rR, rF;

  always @(posedge clk) begin
    if (!rstN) begin
      mTxPrev = 0; mRxPrev = 0; mEnPrev = 1; mGePrev = 0;
      mPendR = 0; mPendF = 0; mBusErr = 0; mShort = 0; mOt = 0; mTo = 0;
      mLow = '0; mHigh = '0; lvl = 0; toCnt = 0;
    end else begin
      nrm    = (mode == 2'b10);
      drvReq = nrm && !txEnN && ge;
      act    = drvReq && !mTo && !mOt;
      tR = txData && !mTxPrev;  tF = !txData && mTxPrev;
      rR = rxData && !mRxPrev;  rF = !rxData && mRxPrev;
      if (mode == 2'b00) begin
        mPendR = 0; mPendF = 0; mBusErr = 0; mShort = 0; mOt = 0; mTo = 0;
        mLow = '0; mHigh = '0; lvl = 0; toCnt = 0;
      end else begin
        if (act) begin
          if ((tR && mPendR && !rR) || (tF && mPendF && !rF)) mBusErr = 1;
          else if ((rR && mPendR) || (rF && mPendF)) mBusErr = 0;
          if (tR) mPendR = 1; else if (rR) mPendR = 0;
          if (tF) mPendF = 1; else if (rF) mPendF = 0;
        end else begin
          mPendR = 0; mPendF = 0;
        end
        if (act && txData == mTxPrev) begin
          if (lvl >= ERR) begin
            if (txData) begin
              mLow[0] = curLow[0]; mLow[3] = curLow[3];
              mHigh[0] = curHigh[0]; mHigh[3] = curHigh[3];
            end else begin
              mLow[1] = curLow[1]; mLow[2] = curLow[2];
              mHigh[1] = curHigh[1]; mHigh[2] = curHigh[2];
            end
          end
          if (lvl == ERR) mShort = shortCmp;
          if (lvl <= ERR) lvl++;
        end else begin
          lvl = 0;
        end
        if (nrm) mOt = otc;
        if (txEnN != mEnPrev || ge != mGePrev || !nrm) begin
          mTo = 0; toCnt = 0;
        end else if (drvReq && !mTo) begin
          if (toCnt == TO - 1) mTo = 1; else toCnt++;
        end
      end
      mTxPrev = txData; mRxPrev = rxData; mEnPrev = txEnN; mGePrev = ge;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic compareAll();
    logic expAny;
    expAny = mBusErr | (|mLow) | (|mHigh) | mShort | mOt | mTo | iouv;
    chk("R1 txDrive", 32'(txDrive), 32'(mode == 2'b10 && !txEnN && ge && !mTo && !mOt));
    chk("R2 R3 R4 R5 busErr", 32'(busErr), 32'(mBusErr));
    chk("R6 lowFlags", 32'(lowFlags), 32'(mLow));
    chk("R6 highFlags", 32'(highFlags), 32'(mHigh));
    chk("R7 openLine", 32'(openLine), 32'({mLow[2] & mLow[3], mLow[0] & mLow[1]}));
    chk("R7 shortSup", 32'(shortSup), 32'({mLow[2] & mHigh[3], mLow[0] & mHigh[1]}));
    chk("R7 shortGnd", 32'(shortGnd), 32'({mHigh[2] & mLow[3], mHigh[0] & mLow[1]}));
    chk("R8 lineShort", 32'(lineShort), 32'(mShort));
    chk("R11 overTemp", 32'(overTemp), 32'(mOt));
    chk("R9 R10 txTimeout", 32'(txTimeout), 32'(mTo));
    chk("R12 anyErr", 32'(anyErr), 32'(expAny));
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic echoPairs(input int n);
    for (int i = 0; i < n; i++) begin
      txData = ~txData; tick(1);
      rxData = txData;  tick(1);
    end
  endtask

  task automatic lonePulses(input int n);
    for (int i = 0; i < n; i++) begin
      txData = ~txData; tick(1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tick(1);
    // R13 reset state
    chk("R13 reset flags", 32'({busErr, lowFlags, highFlags, lineShort, overTemp, txTimeout, anyErr}), 32'h0);

    mode = 2'b10; txEnN = 1'b0; ge = 1'b1;
    tick(2);
    chk("R1 enable", 32'(txDrive), 32'h1);

    echoPairs(6);
    chk("R4 echoed no error", 32'(busErr), 32'h0);

    lonePulses(4);
    chk("R2 unechoed rises", 32'(busErr), 32'h1);

    echoPairs(4);
    chk("R4 echo clears", 32'(busErr), 32'h0);

    // falling-edge rule alone
    txData = 1; tick(1); rxData = 1; tick(1);
    txData = 0; tick(1); txData = 1; tick(1); txData = 0; tick(1);
    chk("R3 unechoed falls", 32'(busErr), 32'h1);
    rxData = 0; tick(1);
    chk("R4 fall echo clears", 32'(busErr), 32'h0);

    // held while disabled
    lonePulses(4);
    chk("R2 error again", 32'(busErr), 32'h1);
    txEnN = 1'b1; tick(1);
    echoPairs(4);
    chk("R5 held while off", 32'(busErr), 32'h1);
    txEnN = 1'b0; tick(1);
    echoPairs(4);
    chk("R5 fresh pairing clears", 32'(busErr), 32'h0);

    // current sampling per level
    txData = 1; rxData = 1; curLow = 4'b1001; curHigh = 4'b0000;
    tick(ERR + 4);
    chk("R6 data1 sample", 32'(lowFlags), 32'h9);
    curLow = 4'b1111; tick(2);
    chk("R6 data0 drivers hold", 32'(lowFlags), 32'h9);
    txData = 0; rxData = 0; curLow = 4'b0110; tick(2);
    chk("R6 settle window", 32'(lowFlags), 32'h9);
    tick(ERR + 2);
    chk("R6 data0 sample", 32'(lowFlags), 32'hF);
    chk("R7 both lines open", 32'(openLine), 32'h3);

    txData = 1; rxData = 1; curLow = 4'b0001; curHigh = 4'b0000; tick(ERR + 3);
    txData = 0; rxData = 0; curLow = 4'b0000; curHigh = 4'b0010; tick(ERR + 3);
    chk("R7 plus short to supply", 32'(shortSup), 32'h1);
    chk("R7 no open", 32'(openLine), 32'h0);

    // line short sampled once per level
    txData = 1; rxData = 1; shortCmp = 1; tick(ERR + 3);
    chk("R8 sampled", 32'(lineShort), 32'h1);
    shortCmp = 0; tick(3);
    chk("R8 held", 32'(lineShort), 32'h1);
    txData = 0; rxData = 0; tick(ERR + 3);
    chk("R8 resampled", 32'(lineShort), 32'h0);

    // timeout
    tick(TO + 3);
    chk("R9 timeout set", 32'(txTimeout), 32'h1);
    chk("R9 drive cut", 32'(txDrive), 32'h0);
    ge = 1'b0; tick(1);
    chk("R10 guard edge clears", 32'(txTimeout), 32'h0);
    ge = 1'b1; tick(1);

    // temperature
    mode = 2'b01; otc = 1; tick(3);
    chk("R11 ignored in standby", 32'(overTemp), 32'h0);
    mode = 2'b10; tick(2);
    chk("R11 set in normal", 32'(overTemp), 32'h1);
    chk("R11 drive blocked", 32'(txDrive), 32'h0);
    otc = 0; tick(2);
    chk("R11 follows comparator", 32'(overTemp), 32'h0);

    // power off and undervoltage
    mode = 2'b00; tick(2);
    chk("R13 power off clears", 32'({busErr, lowFlags, highFlags, lineShort, overTemp, txTimeout}), 32'h0);
    iouv = 1; tick(1);
    chk("R12 undervoltage aggregate", 32'(anyErr), 32'h1);
    iouv = 0; tick(1);
    chk("R12 aggregate idle", 32'(anyErr), 32'h0);

    // random mix
    mode = 2'b10;
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(99) < 30) txData = ~txData;
      if ($urandom_range(99) < 70) rxData = txData;
      else if ($urandom_range(99) < 20) rxData = ~rxData;
      if ($urandom_range(99) < 2) txEnN = ~txEnN;
      if ($urandom_range(99) < 2) ge = ~ge;
      if ($urandom_range(99) < 3) mode = ($urandom_range(9) < 7) ? 2'b10 : 2'(($urandom_range(2)) == 0 ? 2'b00 : ($urandom_range(1) ? 2'b01 : 2'b11));
      if ($urandom_range(99) < 10) begin curLow = 4'($urandom); curHigh = 4'($urandom); end
      if ($urandom_range(99) < 10) shortCmp = ~shortCmp;
      if ($urandom_range(99) < 3) otc = ~otc;
      if ($urandom_range(99) < 2) iouv = ~iouv;
      tick(1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule